// File: doc/BRIEF.md
# Up/Down Timer with Capture and Clock-Out

This block is a 16-bit timer/counter for a microcontroller subsystem. One control word picks its role. It can be a reload timer that counts up, or, with direction control on, counts up or down under an external control pin. It can latch its count when that pin falls. It can act as a tick source for a serial port's bit-rate clock. It can also act as a divide-by-reload clock generator whose output has an even duty cycle.

Software reaches the block through one write port. A select field steers the write data to one of three places: the live count, the shared reload/capture register, or the control word. The control word also carries the two sticky flags, so one control write can clear or set them. The count source is either every system clock or every falling edge of an external count pin. Both external pins pass through a two-flop synchroniser and then an edge-detect stage before they affect the counter.

The block drives four outputs. The overflow and capture-edge flags feed an interrupt controller. A one-cycle baud tick feeds a serial port. A square wave drives a pin. All of these are plain control and status signals, with no handshake.

Top module: `updown_timer`

## Requirements
- R1: After reset the count, the reload/capture register, both flags, baud_tick, clk_out and dir_toggle are 0. The control word is 0, which means a stopped, up-only reload timer.
- R2: In reload mode with direction control off, each count step adds one to the count. A step taken at 0xFFFF loads the reload value and sets ovf_flag.
- R3: In reload mode with direction control on, a synchronised ex_pin of 1 counts up and a 0 counts down. A down step taken when the count equals the reload value loads 0xFFFF and sets ovf_flag.
- R4: With direction control on in reload mode, dir_toggle inverts on every overflow and every underflow. Otherwise dir_toggle holds its value.
- R5: In capture mode with the EX-enable bit set, a synchronised falling edge on ex_pin copies the count into the reload/capture register and sets ex_flag. In capture mode the count wraps from 0xFFFF to 0 and sets ovf_flag.
- R6: In capture mode with the EX-enable bit clear, ex_pin edges leave the reload/capture register and ex_flag unchanged.
- R7: If either serial clock select bit is set, the block is in baud mode, and this mode takes priority over all the others. Each step taken at 0xFFFF reloads the count and gives baud_tick high for exactly one cycle. ovf_flag is not set.
- R8: If capture select is 0 and output enable is 1, with no serial clock select bit set, the block is in clock-out mode. Each step taken at 0xFFFF reloads the count and inverts clk_out, which gives a 50% duty cycle. ovf_flag is not set.
- R9: With the external-count bit set, the counter takes one step per synchronised falling edge of cnt_pin. Otherwise it takes one step per clock.
- R10: With the run bit clear, the count holds its value.
- R11: The wr_sel codes are 0 for the count, 1 for the reload/capture register, 2 for the control word, and 3, which is ignored. The control word bits are 0 run, 1 external count, 2 capture select, 3 EX enable, 4 direction enable, 5 output enable, 6 transmit select and 7 receive select. Bit 8 writes ovf_flag and bit 9 writes ex_flag. A write takes precedence over a hardware update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_pin | input | 1 | External count input, active on its falling edge |
| ex_pin | input | 1 | External control pin: sets direction, or triggers a capture |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current count |
| reload_o | output | 16 | Reload/capture register |
| ovf_flag | output | 1 | Sticky overflow/underflow flag |
| ex_flag | output | 1 | Sticky EX-edge flag |
| baud_tick | output | 1 | One-cycle tick on each baud-mode overflow |
| clk_out | output | 1 | Divided clock output |
| dir_toggle | output | 1 | Inverts on each up/down-mode overflow or underflow |

## Verification
The bench goes after the underflow point in down counting. A design that compares against zero instead of the reload value would reload at the wrong count, and one that reloads the reload value instead of 0xFFFF would hold a wrong count. The bench sets more than one mode bit at once, with capture select and a serial select both set. A wrong mode priority shows up there as ovf_flag being set, or as a missing baud tick. Other corner cases covered are a capture with the EX-enable bit clear, where a leaky enable would overwrite the register, and a control write landing in the same cycle as an overflow, where the wrong precedence would leave ovf_flag set. The bench also checks the count after a known number of pulses on the external count pin, which exposes a wrong edge polarity or a missing synchroniser stage.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {MD_RELOAD, MD_CAPTURE, MD_BAUD, MD_CLKOUT} tmr_mode_e;

  // packed: run is bit 0, rx_sel is bit 7
  typedef struct packed {
    logic rx_sel;
    logic tx_sel;
    logic out_en;
    logic dir_en;
    logic ex_en;
    logic cap_sel;
    logic ext_cnt;
    logic run;
  } tmr_ctrl_t;

  localparam int CTRL_W  = 8;
  localparam int OVF_BIT = 8;
  localparam int EXF_BIT = 9;
  localparam logic [1:0] WSEL_CNT  = 2'd0;
  localparam logic [1:0] WSEL_RLD  = 2'd1;
  localparam logic [1:0] WSEL_CTRL = 2'd2;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic lvl_d
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= pin;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= chain[STAGES-1];

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wdata,
  output tmr_ctrl_t         ctrl,
  output tmr_mode_e         mode
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl <= '0;
    else if (wr_ctrl) ctrl <= tmr_ctrl_t'(wdata);

  // serial select wins, then clock-out, then capture
  always_comb begin
    if (ctrl.tx_sel || ctrl.rx_sel)        mode = MD_BAUD;
    else if (!ctrl.cap_sel && ctrl.out_en) mode = MD_CLKOUT;
    else if (ctrl.cap_sel)                 mode = MD_CAPTURE;
    else                                   mode = MD_RELOAD;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_ctrl_t    ctrl,
  input  tmr_mode_e    mode,
  input  logic         step,
  input  logic         ex_lvl,
  input  logic         ex_fall,
  input  logic         wr_cnt,
  input  logic         wr_rld,
  input  logic         wr_flags,
  input  logic [W-1:0] wdata,
  input  logic         ovf_wr,
  input  logic         exf_wr,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output logic         ovf_q,
  output logic         exf_q,
  output logic         tick_q,
  output logic         cko_q,
  output logic         tog_q
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] cnt_n, rld_n;
  logic         ovf_n, exf_n, tick_n, cko_n, tog_n;
  logic         at_max, at_rld, go_up;

  assign at_max = (cnt_q == ALL_ONES);
  assign at_rld = (cnt_q == rld_q);
  assign go_up  = !ctrl.dir_en || ex_lvl;

  always_comb begin
    cnt_n  = cnt_q;
    rld_n  = rld_q;
    ovf_n  = ovf_q;
    exf_n  = exf_q;
    tick_n = 1'b0;
    cko_n  = cko_q;
    tog_n  = tog_q;
    if (step) begin
      unique case (mode)
        MD_RELOAD: begin
          if (go_up) begin
            if (at_max) begin
              cnt_n = rld_q;
              ovf_n = 1'b1;
              if (ctrl.dir_en) tog_n = !tog_q;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end else if (at_rld) begin
            cnt_n = ALL_ONES;
            ovf_n = 1'b1;
            tog_n = !tog_q;
          end else begin
            cnt_n = cnt_q - 1'b1;
          end
        end
        MD_CAPTURE: begin
          cnt_n = cnt_q + 1'b1;
          if (at_max) ovf_n = 1'b1;
        end
        MD_BAUD: begin
          if (at_max) begin
            cnt_n  = rld_q;
            tick_n = 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        MD_CLKOUT: begin
          if (at_max) begin
            cnt_n = rld_q;
            cko_n = !cko_q;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (mode == MD_CAPTURE && ctrl.ex_en && ex_fall) begin
      rld_n = cnt_q;
      exf_n = 1'b1;
    end
    if (wr_cnt) cnt_n = wdata;
    if (wr_rld) rld_n = wdata;
    if (wr_flags) begin
      ovf_n = ovf_wr;
      exf_n = exf_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      ovf_q  <= 1'b0;
      exf_q  <= 1'b0;
      tick_q <= 1'b0;
      cko_q  <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      rld_q  <= rld_n;
      ovf_q  <= ovf_n;
      exf_q  <= exf_n;
      tick_q <= tick_n;
      cko_q  <= cko_n;
      tog_q  <= tog_n;
    end
endmodule

// File: rtl/updown_timer.sv
module updown_timer
  import tmr_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_pin,
  input  logic         ex_pin,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_o,
  output logic [W-1:0] reload_o,
  output logic         ovf_flag,
  output logic         ex_flag,
  output logic         baud_tick,
  output logic         clk_out,
  output logic         dir_toggle
);
  localparam int NPIN  = 2;
  localparam int P_CNT = 0;
  localparam int P_EX  = 1;

  tmr_ctrl_t       ctrl_w;
  tmr_mode_e       mode_w;
  logic [NPIN-1:0] pins, lvl, lvl_d, fall;
  logic            step, wr_ctrl;

  assign pins = {ex_pin, cnt_pin};

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_sync
      tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pins[i]),
        .lvl  (lvl[i]),
        .lvl_d(lvl_d[i])
      );
      assign fall[i] = lvl_d[i] & ~lvl[i];
    end
  endgenerate

  assign wr_ctrl = wr_en && (wr_sel == WSEL_CTRL);

  tmr_ctrl_regs u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ctrl(wr_ctrl),
    .wdata  (wr_data[CTRL_W-1:0]),
    .ctrl   (ctrl_w),
    .mode   (mode_w)
  );

  assign step = ctrl_w.run && (ctrl_w.ext_cnt ? fall[P_CNT] : 1'b1);

  tmr_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl_w),
    .mode    (mode_w),
    .step    (step),
    .ex_lvl  (lvl[P_EX]),
    .ex_fall (fall[P_EX]),
    .wr_cnt  (wr_en && (wr_sel == WSEL_CNT)),
    .wr_rld  (wr_en && (wr_sel == WSEL_RLD)),
    .wr_flags(wr_ctrl),
    .wdata   (wr_data),
    .ovf_wr  (wr_data[OVF_BIT]),
    .exf_wr  (wr_data[EXF_BIT]),
    .cnt_q   (count_o),
    .rld_q   (reload_o),
    .ovf_q   (ovf_flag),
    .exf_q   (ex_flag),
    .tick_q  (baud_tick),
    .cko_q   (clk_out),
    .tog_q   (dir_toggle)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input tmr_ctrl_t    ctrl,
  input tmr_mode_e    mode,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [W-1:0] count_o,
  input logic         ovf_flag,
  input logic         ex_flag,
  input logic         baud_tick,
  input logic         clk_out,
  input logic         dir_toggle
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_sel == WSEL_CTRL);

  // R7
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(ctrl_wr) || $past(mode == MD_RELOAD) || $past(mode == MD_CAPTURE));

  // R7
  tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(mode == MD_BAUD));

  // R8
  cko_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_out) |-> $past(mode == MD_CLKOUT));

  // R4
  tog_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_toggle) |-> $past(mode == MD_RELOAD) && $past(ctrl.dir_en));

  // R5
  exf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ex_flag) |-> $past(ctrl_wr) || ($past(mode == MD_CAPTURE) && $past(ctrl.ex_en)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !wr_en) |=> $stable(count_o));
endmodule

bind updown_timer tmr_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl      (ctrl_w),
  .mode      (mode_w),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .count_o   (count_o),
  .ovf_flag  (ovf_flag),
  .ex_flag   (ex_flag),
  .baud_tick (baud_tick),
  .clk_out   (clk_out),
  .dir_toggle(dir_toggle)
);

// File: tb/sim_updown_timer.sv
module sim_updown_timer;
  localparam int C_RUN = 1, C_EXT = 2, C_CAP = 4, C_EXEN = 8;
  localparam int C_DIR = 16, C_OUT = 32, C_TX = 64, C_RX = 128;
  localparam int F_OVF = 256, F_EXF = 512;

  logic        clk = 0, rst_n = 0;
  logic        cnt_pin = 1, ex_pin = 1, wr_en = 0;
  logic [1:0]  wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] count_o, reload_o;
  logic        ovf_flag, ex_flag, baud_tick, clk_out, dir_toggle;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  updown_timer u0 (.*);

  // behavioural reference model
  int  m_cnt, m_rld, m_ctl;
  bit  m_ovf, m_exf, m_tick, m_cko, m_tog;
  bit  ex0, ex1, exd, c0, c1, cd;
  int  m_mode; // 0 reload 1 capture 2 baud 3 clkout

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rld = 0; m_ctl = 0; m_ovf = 0; m_exf = 0;
      m_tick = 0; m_cko = 0; m_tog = 0;
      ex0 = 0; ex1 = 0; exd = 0; c0 = 0; c1 = 0; cd = 0;
    end else begin
      int  n_cnt, n_rld, n_ctl;
      bit  n_ovf, n_exf, n_cko, n_tog, n_tick, stp, exfall, up;
      exfall = exd && !ex1;
      stp = (m_ctl & C_RUN) != 0 && ((m_ctl & C_EXT) != 0 ? (cd && !c1) : 1'b1);
      if (m_ctl & (C_TX | C_RX)) m_mode = 2;
      else if (!(m_ctl & C_CAP) && (m_ctl & C_OUT)) m_mode = 3;
      else if (m_ctl & C_CAP) m_mode = 1;
      else m_mode = 0;
      n_cnt = m_cnt; n_rld = m_rld; n_ctl = m_ctl; n_ovf = m_ovf; n_exf = m_exf;
      n_cko = m_cko; n_tog = m_tog; n_tick = 0;
      up = !(m_ctl & C_DIR) || ex1;
      if (stp) begin
        if (m_mode == 0 && !up) begin
          if (m_cnt == m_rld) begin n_cnt = 65535; n_ovf = 1; n_tog = !m_tog; end
          else n_cnt = m_cnt - 1;
        end else if (m_mode == 1) begin
          n_cnt = (m_cnt + 1) % 65536;
          if (m_cnt == 65535) n_ovf = 1;
        end else begin
          if (m_cnt == 65535) begin
            n_cnt = m_rld;
            if (m_mode == 0) begin n_ovf = 1; if (m_ctl & C_DIR) n_tog = !m_tog; end
            if (m_mode == 2) n_tick = 1;
            if (m_mode == 3) n_cko = !m_cko;
          end else n_cnt = m_cnt + 1;
        end
      end
      if (m_mode == 1 && (m_ctl & C_EXEN) && exfall) begin n_rld = m_cnt; n_exf = 1; end
      if (wr_en && wr_sel == 0) n_cnt = wr_data;
      if (wr_en && wr_sel == 1) n_rld = wr_data;
      if (wr_en && wr_sel == 2) begin
        n_ctl = wr_data & 255; n_ovf = wr_data[8]; n_exf = wr_data[9];
      end
      m_cnt = n_cnt; m_rld = n_rld; m_ctl = n_ctl; m_ovf = n_ovf; m_exf = n_exf;
      m_cko = n_cko; m_tog = n_tog; m_tick = n_tick;
      exd = ex1; ex1 = ex0; ex0 = ex_pin;
      cd = c1; c1 = c0; c0 = cnt_pin;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tg;
      case (m_mode)
        1: tg = "R5";
        2: tg = "R7";
        3: tg = "R8";
        default: tg = "R2";
      endcase
      chk(count_o == m_cnt[15:0], {tg, " count"}, count_o, m_cnt);
      chk(reload_o == m_rld[15:0], {tg, " reload"}, reload_o, m_rld);
      chk(ovf_flag == m_ovf, {tg, " ovf"}, ovf_flag, m_ovf);
      chk(ex_flag == m_exf, {tg, " exf"}, ex_flag, m_exf);
      chk(baud_tick == m_tick, {tg, " tick"}, baud_tick, m_tick);
      chk(clk_out == m_cko, {tg, " clk_out"}, clk_out, m_cko);
      chk(dir_toggle == m_tog, "R4 dir_toggle", dir_toggle, m_tog);
    end
  end

  // call at a negedge; leaves at the next negedge
  task automatic wr(input logic [1:0] sel, input int d);
    wr_en = 1; wr_sel = sel; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ticks, highs;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk(count_o == 0 && reload_o == 0, "R1 regs", count_o, 0);
    chk(!ovf_flag && !ex_flag && !baud_tick && !clk_out && !dir_toggle, "R1 outs",
        {ovf_flag, ex_flag, baud_tick, clk_out, dir_toggle}, 0);

    // R2 up-count reload
    wr(1, 'h1234); wr(0, 'hFFFD); wr(2, C_RUN);
    idle(6);
    chk(ovf_flag == 1, "R2 ovf set", ovf_flag, 1);
    chk(count_o > 16'h1234 && count_o < 16'h1240, "R2 reloaded", count_o, 'h1236);

    // R3 down count underflow at reload value
    wr(2, C_DIR); ex_pin = 0; idle(4);
    wr(0, 'h1236); wr(2, C_RUN | C_DIR);
    idle(6);
    chk(ovf_flag == 1, "R3 underflow ovf", ovf_flag, 1);
    chk(count_o > 16'hFFF0, "R3 wrap to top", count_o, 'hFFFC);
    chk(dir_toggle == 1, "R4 toggle on underflow", dir_toggle, 1);
    wr(2, C_DIR); ex_pin = 1; idle(4);
    wr(0, 'hFFFE); wr(2, C_RUN | C_DIR);
    idle(5);
    chk(dir_toggle == 0, "R4 toggle on overflow", dir_toggle, 0);
    chk(ovf_flag == 1, "R3 up ovf", ovf_flag, 1);

    // R5 capture on falling ex edge
    wr(2, C_CAP | C_EXEN); wr(0, 'h4321);
    ex_pin = 0; idle(5);
    chk(reload_o == 16'h4321, "R5 captured", reload_o, 'h4321);
    chk(ex_flag == 1, "R5 ex_flag", ex_flag, 1);
    // R6 edge ignored without enable
    wr(2, C_CAP); ex_pin = 1; idle(4);
    wr(0, 'h5555); ex_pin = 0; idle(5);
    chk(reload_o == 16'h4321, "R6 reload kept", reload_o, 'h4321);
    chk(ex_flag == 0, "R6 ex_flag kept", ex_flag, 0);
    // R5 wrap in capture mode
    wr(2, C_RUN | C_CAP); wr(0, 'hFFFE); idle(3);
    chk(ovf_flag == 1 && count_o < 16'h0008, "R5 wrap ovf", count_o, 1);
    chk(reload_o == 16'h4321, "R5 no reload on wrap", reload_o, 'h4321);

    // R7 baud ticks, priority over capture select
    ex_pin = 1;
    wr(1, 'hFFFC); wr(0, 'hFFFC); wr(2, C_RUN | C_TX | C_CAP);
    ticks = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); ticks += baud_tick; end
    chk(ticks == 10, "R7 tick count", ticks, 10);
    chk(ovf_flag == 0, "R7 no ovf", ovf_flag, 0);
    wr(2, C_RUN | C_RX); idle(8);
    chk(ovf_flag == 0, "R7 rx select no ovf", ovf_flag, 0);

    // R8 clock out, 50% duty
    wr(1, 'hFFFE); wr(0, 'hFFFE); wr(2, C_RUN | C_OUT);
    idle(4);
    highs = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); highs += clk_out; end
    chk(highs == 20, "R8 duty", highs, 20);
    chk(ovf_flag == 0, "R8 no ovf", ovf_flag, 0);

    // R9 external count
    wr(2, C_RUN | C_EXT); wr(0, 'h0100); idle(4);
    for (int i = 0; i < 3; i++) begin cnt_pin = 0; idle(3); cnt_pin = 1; idle(3); end
    idle(4);
    chk(count_o == 16'h0103, "R9 pulse count", count_o, 'h0103);

    // R10 hold while stopped
    wr(2, 0); wr(0, 'h0200); idle(10);
    chk(count_o == 16'h0200, "R10 hold", count_o, 'h0200);

    // R11 write precedence and ignored select
    wr(1, 0); wr(2, C_RUN);
    wr(0, 'hFFFF); wr(2, C_RUN);
    chk(ovf_flag == 0, "R11 write beats ovf", ovf_flag, 0);
    chk(count_o == 16'h0000, "R11 reload still applied", count_o, 0);
    wr(2, F_OVF | F_EXF); idle(1);
    chk(ovf_flag && ex_flag, "R11 flags written", {ovf_flag, ex_flag}, 3);
    wr(3, 'hABCD); idle(1);
    chk(count_o == 16'h0001 && reload_o == 16'h0000, "R11 sel 3 ignored", count_o, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule